// File: doc/BRIEF.md
# Chained Descriptor Transfer Controller

This block is a trigger-driven copy engine. It works from a small register array of transfer descriptors. Each descriptor holds a source address, a destination address, a 16-bit transfer counter, a repeat base address, a repeat reload count and a 7-bit mode field. Each accepted trigger starts an activation at descriptor 0. For each descriptor in the activation, the engine reads one byte from the source, writes it to the destination and then writes back the updated addresses and counter. If the mode allows, it then goes on to the next descriptor.

A descriptor can chain on every activation, or only on the activation in which its counter runs out. If a destination address falls inside the descriptor window, the write lands in a byte of a descriptor register and no bus cycle takes place. This lets a repeat-mode descriptor that is chained behind a normal one rewrite the upper byte of the normal descriptor's destination address. With a 16-bit counter, the destination then alternates between address pages without end. Normal-mode descriptors raise a one-cycle interrupt pulse. Repeat-mode descriptors never do.

Software loads the descriptors through a simple configuration port while the engine is idle.

Top module: `xfer_chain`

## Requirements
- R1: While reset is held and right after it, `busy`, `irq` and `mem_req` are low.
- R2: A `trig` sampled while idle starts an activation, and `busy` is high from the next cycle until the last descriptor of the chain has been written back. A `trig` that arrives while busy is held in a one-deep pending flag and starts one more activation once idle.
- R3: Each descriptor moves one byte: a read at the source address, then a write of that byte to the destination address. While `mem_req` is high and `mem_ready` is low, the request, address and direction hold steady.
- R4: Mode bit 0 set makes the source address increment after a transfer, and clear keeps it fixed. Mode bit 1 does the same for the destination address. In normal mode (bit 2 clear) the counter decrements modulo 2^16, so a loaded count of 0 means 65,536 transfers before it runs out.
- R5: A normal-mode descriptor pulses `irq` for one cycle during its write-back. It pulses on every transfer when mode bit 6 is set, and otherwise only when its counter goes from 1 to 0.
- R6: In repeat mode (bit 2 set), mode bit 3 selects the repeat side: 1 is the source, 0 is the destination. When the counter goes from 1 to 0, that side's address is restored to the repeat base and the counter to the reload count. Repeat mode never raises `irq`.
- R7: Mode bit 4 set makes the activation continue with the next descriptor. When it is clear, or at the last descriptor, the activation ends.
- R8: Mode bit 5 set limits chaining to the activation in which the counter went from 1 to 0. On all other activations the chain ends at that descriptor.
- R9: A destination whose bits above bit 7 equal the window page and whose bits [7:4] are below the descriptor count writes the byte into descriptor [7:4] and issues no bus cycle. Byte offsets b in bits [3:0] select the targets: 0+b is source byte b, 4+b is destination byte b, and 8+b is counter byte b.
- R10: A descriptor's write-back completes before the next descriptor is loaded, so a change made during a chain is seen on the following trigger.
- R11: A configuration write (`cfg_fld`: 0 source, 1 destination, 2 counter, 3 mode, 4 repeat base, 5 reload count) takes effect only while idle. While busy it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Transfer trigger |
| busy | output | 1 | Activation in progress |
| irq | output | 1 | One-cycle interrupt request pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Descriptor index to configure |
| cfg_fld | input | 3 | Field select |
| cfg_wdata | input | AW | Field value |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write (1) or read (0) |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Bus write data |
| mem_rdata | input | DW | Bus read data |
| mem_ready | input | 1 | Bus handshake completion |

## Verification
`busy` is due one cycle after an accepted trigger. The read of a descriptor completes on the first edge with `mem_ready` high, and its write on the next such edge. In-window writes take exactly one cycle. The write-back and any `irq` pulse follow one cycle after that. The bench changes inputs and samples outputs on falling edges, so each bus handshake and each interrupt pulse is seen exactly once. Expected writes go into a scoreboard queue that a monitor drains as write handshakes occur. After each activation, the interrupt count and the empty queue are checked.

// File: rtl/xfer_chain.sv
module xfer_chain #(
  parameter int AW   = 24,
  parameter int DW   = 8,
  parameter int ND   = 4,
  parameter int CW   = 16,
  parameter int PAGE = 'hFFFF,
  localparam int IW  = $clog2(ND),
  localparam int AB  = AW / 8,
  localparam int PW  = AW - 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  output logic          busy,
  output logic          irq,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [2:0]    cfg_fld,
  input  logic [AW-1:0] cfg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);
  typedef enum logic [1:0] {IDLE, RD, WR, WB} st_t;
  st_t st;

  logic [AW-1:0] s_a [ND];
  logic [AW-1:0] d_a [ND];
  logic [AW-1:0] r_a [ND];
  logic [CW-1:0] c_n [ND];
  logic [CW-1:0] r_n [ND];
  logic [6:0]    md  [ND];

  logic [IW-1:0] cur;
  logic [DW-1:0] dbuf;
  logic          pend;

  logic [6:0]    m;
  logic [CW-1:0] cnt;
  logic          last, win, chain;
  logic [IW-1:0] wi;
  logic [3:0]    wsel;

  assign m     = md[cur];
  assign cnt   = c_n[cur];
  assign last  = cnt == CW'(1);
  assign wsel  = d_a[cur][7:4];
  assign wi    = wsel[IW-1:0];
  assign win   = (d_a[cur][AW-1:8] == PW'(PAGE)) && (wsel < 4'(ND));
  assign chain = m[4] && (!m[5] || last) && (cur != IW'(ND - 1));

  assign busy      = st != IDLE;
  assign mem_req   = (st == RD) || (st == WR && !win);
  assign mem_we    = st == WR;
  assign mem_addr  = (st == RD) ? s_a[cur] : d_a[cur];
  assign mem_wdata = dbuf;
  assign irq       = (st == WB) && !m[2] && (m[6] || last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      cur  <= '0;
      dbuf <= '0;
      pend <= 1'b0;
      for (int i = 0; i < ND; i++) begin
        s_a[i] <= '0; d_a[i] <= '0; r_a[i] <= '0;
        c_n[i] <= '0; r_n[i] <= '0; md[i]  <= '0;
      end
    end else begin
      if (busy && trig) pend <= 1'b1;
      case (st)
        IDLE: begin
          if (cfg_we) begin
            case (cfg_fld)
              3'd0: s_a[cfg_idx] <= cfg_wdata;
              3'd1: d_a[cfg_idx] <= cfg_wdata;
              3'd2: c_n[cfg_idx] <= cfg_wdata[CW-1:0];
              3'd3: md[cfg_idx]  <= cfg_wdata[6:0];
              3'd4: r_a[cfg_idx] <= cfg_wdata;
              3'd5: r_n[cfg_idx] <= cfg_wdata[CW-1:0];
              default: ;
            endcase
          end
          if (trig || pend) begin
            st   <= RD;
            cur  <= '0;
            pend <= 1'b0;
          end
        end
        RD: if (mem_ready) begin
          dbuf <= mem_rdata;
          st   <= WR;
        end
        WR: begin
          if (win) begin
            for (int b = 0; b < AB; b++) begin
              if (d_a[cur][3:0] == 4'(b))     s_a[wi][8*b +: 8] <= dbuf[7:0];
              if (d_a[cur][3:0] == 4'(4 + b)) d_a[wi][8*b +: 8] <= dbuf[7:0];
            end
            for (int b = 0; b < CW / 8; b++)
              if (d_a[cur][3:0] == 4'(8 + b)) c_n[wi][8*b +: 8] <= dbuf[7:0];
            st <= WB;
          end else if (mem_ready) begin
            st <= WB;
          end
        end
        WB: begin
          if (m[2] && last) c_n[cur] <= r_n[cur];
          else              c_n[cur] <= cnt - CW'(1);
          if (m[2] && m[3] && last) s_a[cur] <= r_a[cur];
          else if (m[0])            s_a[cur] <= s_a[cur] + AW'(1);
          if (m[2] && !m[3] && last) d_a[cur] <= r_a[cur];
          else if (m[1])             d_a[cur] <= d_a[cur] + AW'(1);
          if (chain) begin
            cur <= cur + 1'b1;
            st  <= RD;
          end else begin
            st <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_chain_chk.sv
module xfer_chain_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic          busy,
  input logic          irq,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready
);
  // R3
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R3
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !busy |=> busy);
  // R5
  irq_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> busy);
  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !busy && !mem_req && !irq);
endmodule

bind xfer_chain xfer_chain_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .busy(busy), .irq(irq),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/xfer_chain_test.sv
module xfer_chain_test;
  localparam int AW = 24;
  localparam int DW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic busy, irq;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [2:0] cfg_fld = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic mem_ready = 1'b0;
  logic [7:0] mem [256];

  int checks = 0;
  int errors = 0;
  int irqs = 0;
  logic [AW-1:0] exp_a[$];
  logic [DW-1:0] exp_d[$];
  string exp_t[$];

  always #2.5 clk = ~clk;

  xfer_chain uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .busy(busy), .irq(irq),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) mem_ready <= rst_n && mem_req && !mem_ready;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && irq) irqs++;
    if (rst_n && mem_req && mem_ready && mem_we) begin
      if (exp_a.size() == 0) begin
        chk("R3 unexpected write", longint'(mem_addr), -1);
      end else begin
        string t;
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        t = exp_t.pop_front();
        ea = exp_a.pop_front();
        ed = exp_d.pop_front();
        chk({t, " addr"}, longint'(mem_addr), longint'(ea));
        chk({t, " data"}, longint'(mem_wdata), longint'(ed));
      end
    end
  end

  task automatic expect_wr(string t, logic [AW-1:0] a, logic [7:0] src);
    exp_t.push_back(t);
    exp_a.push_back(a);
    exp_d.push_back(mem[src]);
  endtask

  task automatic cfg(int idx, int fld, logic [AW-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_fld = 3'(fld); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(output int ni);
    int c0;
    c0 = irqs;
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    ni = irqs - c0;
  endtask

  task automatic drained(string t);
    chk({t, " scoreboard empty"}, exp_a.size(), 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    mem[8'h10] = 8'h21;
    mem[8'h11] = 8'h20;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 mem_req", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);

    // R4 R5: fixed source, incrementing destination, irq at exhaustion
    cfg(0, 0, 24'h000040); cfg(0, 1, 24'h200000); cfg(0, 2, 3); cfg(0, 3, 7'h02);
    for (int k = 0; k < 3; k++) begin
      expect_wr("R4", 24'h200000 + AW'(k), 8'h40);
      fire(n);
      chk("R5 irq at zero only", n, (k == 2) ? 1 : 0);
    end
    expect_wr("R4 count zero means 65536", 24'h200003, 8'h40);
    fire(n);
    chk("R4 no irq after wrap to 65535", n, 0);
    drained("R4");

    // R4 R5: incrementing source, irq on every transfer
    cfg(0, 0, 24'h000050); cfg(0, 1, 24'h300000); cfg(0, 2, 5); cfg(0, 3, 7'h43);
    for (int k = 0; k < 2; k++) begin
      expect_wr("R4 src inc", 24'h300000 + AW'(k), 8'(8'h50 + k));
      fire(n);
      chk("R5 irq every transfer", n, 1);
    end
    drained("R5");

    // R6 R7: unconditional chain into a source-repeat descriptor
    cfg(0, 0, 24'h000060); cfg(0, 1, 24'h500000); cfg(0, 2, 100); cfg(0, 3, 7'h12);
    cfg(1, 0, 24'h000030); cfg(1, 4, 24'h000030); cfg(1, 2, 2); cfg(1, 5, 2);
    cfg(1, 1, 24'h600000); cfg(1, 3, 7'h0D);
    for (int k = 0; k < 3; k++) begin
      expect_wr("R7 first", 24'h500000 + AW'(k), 8'h60);
      expect_wr("R6 repeat source", 24'h600000, 8'(8'h30 + (k % 2)));
      fire(n);
      chk("R6 repeat never irq", n, 0);
    end
    drained("R7");

    // R8 R9 R10: chain only at zero, rewrite dest upper byte via window
    cfg(0, 0, 24'h000040); cfg(0, 1, 24'h200000); cfg(0, 2, 2); cfg(0, 3, 7'h32);
    cfg(1, 0, 24'h000010); cfg(1, 4, 24'h000010); cfg(1, 2, 2); cfg(1, 5, 2);
    cfg(1, 1, 24'hFFFF06); cfg(1, 3, 7'h0D);
    expect_wr("R8 no chain", 24'h200000, 8'h40);
    fire(n);
    chk("R8 irq", n, 0);
    expect_wr("R8 chain at zero", 24'h200001, 8'h40);
    fire(n);
    chk("R8 irq at zero", n, 1);
    drained("R9 window write no bus cycle");
    expect_wr("R10 page 21", 24'h210002, 8'h40);
    fire(n);
    cfg(0, 2, 2);
    expect_wr("R9", 24'h210003, 8'h40);
    fire(n);
    expect_wr("R9", 24'h210004, 8'h40);
    fire(n);
    chk("R5 irq second page", n, 1);
    expect_wr("R10 page 20", 24'h200005, 8'h40);
    fire(n);
    drained("R10");

    // R2: trigger while busy is held and served
    cfg(0, 0, 24'h000040); cfg(0, 1, 24'h700000); cfg(0, 2, 10); cfg(0, 3, 7'h02);
    expect_wr("R2 first", 24'h700000, 8'h40);
    expect_wr("R2 pending", 24'h700001, 8'h40);
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    chk("R2 busy", busy, 1);
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    repeat (30) @(negedge clk);
    chk("R2 idle", busy, 0);
    drained("R2");

    // R11: configuration ignored while busy
    expect_wr("R11 before", 24'h700002, 8'h40);
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    cfg_we = 1'b1; cfg_idx = 0; cfg_fld = 3'd1; cfg_wdata = 24'h123456;
    @(negedge clk) cfg_we = 1'b0;
    while (busy) @(negedge clk);
    expect_wr("R11 dest kept", 24'h700003, 8'h40);
    fire(n);
    drained("R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule